// File: doc/BRIEF.md
# Dual-Framing Register Read Sequencer

This block feeds read bytes to the byte engine of an I2C target that fronts a sensor register map. The byte engine reports four events: a start condition, a received register-address byte, a request for the next outgoing data byte, and a stop condition. The sequencer answers each data request with the contents of the register its read pointer selects. It then steps the pointer on, and wraps to 00h after the last implemented register. Registers 00h to 06h hold one conversion's channel data, so one burst can read them all.

A mode input picks the read framing for each transaction.

- **Long framing:** the master writes a register address after the device address, and reads continue from that address.
- **Short framing:** there is no address phase, and every read burst begins at 00h.

In the short framing a 2-bit trigger option can request a one-cycle ADC start strobe. The strobe fires either right after the start condition or right after the byte from register 05h has been delivered. The mode and the trigger option are captured when the start condition arrives.

The register file sits outside the block. It is read through a combinational port: an address goes out and data comes back in the same cycle.

Top module: `reg_read_sequencer`

## Requirements
- R1: After reset, data_valid_o and adc_start_o are 0, reg_addr_o is 00h and data_o is 00h.
- R2: A start with short_mode_i=1 sets reg_addr_o to 00h on the next clock. In the short framing, address bytes (addr_valid_i) have no effect on the pointer.
- R3: A data_req_i inside an open transaction (after start_i, before stop_i) makes data_valid_o high for exactly the next cycle. In that cycle data_o holds reg_rdata_i as it was for the address on reg_addr_o when the request was made. A data_req_i outside a transaction produces no data_valid_o and leaves the pointer unchanged.
- R4: In the long framing (short_mode_i=0 at start), an address byte loads the pointer with addr_byte_i, and the following reads proceed from that address.
- R5: Each delivered byte advances the pointer by one. From NUM_REGS-1 (16h by default), or from any out-of-range address, the pointer goes to 00h.
- R6: A read at an address of NUM_REGS or above delivers 00h, whatever reg_rdata_i holds.
- R7: In the long framing, adc_start_o never fires, whatever trigger option is set.
- R8: In the short framing, trigger option 00 produces no adc_start_o.
- R9: In the short framing, trigger option 01 pulses adc_start_o for one cycle, on the clock after start_i, before any data byte.
- R10: In the short framing, trigger options 10 and 11 pulse adc_start_o for one cycle, together with the data_valid_o of the byte read from register 05h. The pulse fires at most once per transaction, even if the pointer wraps back past 05h.
- R11: short_mode_i and trig_sel_i are sampled only on start_i. Changing them during a transaction has no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| short_mode_i | input | 1 | 1 = short framing (no address phase), 0 = long framing; sampled at start |
| trig_sel_i | input | 2 | ADC trigger option: 00 none, 01 after start, 1x after register 05h; sampled at start |
| start_i | input | 1 | Start condition seen by the byte engine |
| stop_i | input | 1 | Stop condition seen by the byte engine |
| addr_valid_i | input | 1 | Register-address byte received |
| addr_byte_i | input | ADDR_W | Received register address |
| data_req_i | input | 1 | Byte engine requests the next data byte |
| reg_addr_o | output | ADDR_W | Register read port address (current read pointer) |
| reg_rdata_i | input | DATA_W | Register read port data, combinational from reg_addr_o |
| data_o | output | DATA_W | Data byte for the byte engine |
| data_valid_o | output | 1 | data_o is valid this cycle |
| adc_start_o | output | 1 | One-cycle ADC conversion start strobe |

## Verification
The assertions watch these rules on every cycle:
- each delivered byte traces back to a request one cycle earlier;
- the pointer steps by one or wraps to 00h;
- out-of-range reads deliver 00h;
- a short-framing start lands on 00h;
- the ADC strobe never lasts longer than one cycle.

Some behaviours depend on history across a whole transaction, and only the bench scenarios can show them. These are the once-per-transaction limit on the ADC strobe, its silence in the long framing, mode and trigger values ignored mid-transaction, and requests ignored outside a transaction. The bench shows them by running a behavioural model alongside the design and by counting strobes per transaction.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [1:0] {
    TRIG_OFF      = 2'b00,
    TRIG_AT_START = 2'b01,
    TRIG_AFTER_A  = 2'b10,
    TRIG_AFTER_B  = 2'b11
  } trig_sel_e;

  // Both 1x codes select the trigger that follows the block read
  function automatic logic trig_after_block(input logic [1:0] sel);
    return sel[1];
  endfunction
endpackage

// File: rtl/rrs_txn_ctrl.sv
module rrs_txn_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       addr_valid_i,
  input  logic       data_req_i,
  input  logic       short_mode_i,
  input  logic [1:0] trig_sel_i,
  output logic       short_q_o,
  output logic [1:0] trig_q_o,
  output logic       ptr_clr_o,
  output logic       ptr_load_o,
  output logic       ptr_adv_o
);
  logic       active_q;
  logic       short_q;
  logic [1:0] trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      short_q  <= 1'b0;
      trig_q   <= 2'b00;
    end else if (start_i) begin
      active_q <= 1'b1;
      short_q  <= short_mode_i;
      trig_q   <= trig_sel_i;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end
  end

  logic busy_ok;
  assign busy_ok = active_q && !start_i && !stop_i;

  // Priority: start, stop, address byte, data request
  always_comb begin
    ptr_clr_o  = start_i && short_mode_i;
    ptr_load_o = busy_ok && addr_valid_i && !short_q;
    ptr_adv_o  = busy_ok && !ptr_load_o && data_req_i;
  end

  assign short_q_o = short_q;
  assign trig_q_o  = trig_q;
endmodule

// File: rtl/rrs_read_ptr.sv
module rrs_read_ptr #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] LastAddr = ADDR_W'(NUM_REGS - 1);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (clr_i)  ptr_q <= '0;
    else if (load_i) ptr_q <= load_addr_i;
    else if (adv_i)  ptr_q <= (ptr_q >= LastAddr) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rrs_adc_trig.sv
module rrs_adc_trig
  import rrs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int TRIG_REG = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              short_mode_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              short_q_i,
  input  logic [1:0]        trig_q_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              strobe_o
);
  localparam logic [ADDR_W-1:0] TrigAddr = ADDR_W'(TRIG_REG);

  logic fired_q, fire_start, fire_block, strobe_q;

  assign fire_start = start_i && short_mode_i && (trig_sel_i == TRIG_AT_START);
  assign fire_block = adv_i && short_q_i && trig_after_block(trig_q_i) &&
                      (ptr_i == TrigAddr) && !fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= fire_start || fire_block;
      if (start_i)         fired_q <= fire_start;
      else if (fire_block) fired_q <= 1'b1;
    end
  end

  assign strobe_o = strobe_q;
endmodule

// File: rtl/reg_read_sequencer.sv
module reg_read_sequencer #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 23,
  parameter int TRIG_REG = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              short_mode_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_byte_i,
  input  logic              data_req_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              adc_start_o
);
  localparam logic [ADDR_W-1:0] ImplLimit = ADDR_W'(NUM_REGS);

  logic       short_q, ptr_clr, ptr_load, ptr_adv;
  logic [1:0] trig_q;
  logic [ADDR_W-1:0] ptr;

  rrs_txn_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .addr_valid_i, .data_req_i,
    .short_mode_i, .trig_sel_i,
    .short_q_o (short_q),
    .trig_q_o  (trig_q),
    .ptr_clr_o (ptr_clr),
    .ptr_load_o(ptr_load),
    .ptr_adv_o (ptr_adv)
  );

  rrs_read_ptr #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_ptr (
    .clk_i, .rst_ni,
    .clr_i      (ptr_clr),
    .load_i     (ptr_load),
    .adv_i      (ptr_adv),
    .load_addr_i(addr_byte_i),
    .ptr_o      (ptr)
  );

  rrs_adc_trig #(.ADDR_W(ADDR_W), .TRIG_REG(TRIG_REG)) u_trig (
    .clk_i, .rst_ni, .start_i, .short_mode_i, .trig_sel_i,
    .short_q_i(short_q),
    .trig_q_i (trig_q),
    .adv_i    (ptr_adv),
    .ptr_i    (ptr),
    .strobe_o (adc_start_o)
  );

  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= ptr_adv;
      if (ptr_adv) data_q <= (ptr < ImplLimit) ? reg_rdata_i : '0;
    end
  end

  assign reg_addr_o   = ptr;
  assign data_o       = data_q;
  assign data_valid_o = valid_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              short_mode_i,
  input logic              data_req_i,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0] data_o,
  input logic              data_valid_o,
  input logic              adc_start_o
);
  localparam logic [ADDR_W-1:0] LastAddr  = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] ImplLimit = ADDR_W'(NUM_REGS);

  assert_valid_from_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(data_req_i));

  assert_ptr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && $past(reg_addr_o) < LastAddr) |-> reg_addr_o == $past(reg_addr_o) + 1'b1);

  assert_ptr_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && $past(reg_addr_o) >= LastAddr) |-> reg_addr_o == '0);

  assert_unimpl_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && $past(reg_addr_o) >= ImplLimit) |-> data_o == '0);

  assert_short_start_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(start_i) && $past(short_mode_i)) |-> reg_addr_o == '0);

  assert_adc_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);
endmodule

bind reg_read_sequencer rrs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk_i, .rst_ni, .start_i, .short_mode_i, .data_req_i,
  .reg_addr_o, .data_o, .data_valid_o, .adc_start_o
);

// File: tb/reg_read_sequencer_tb.sv
`timescale 1ns/1ps
module reg_read_sequencer_tb;
  localparam int NREG = 23;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       short_mode = 1'b0, start = 1'b0, stop = 1'b0;
  logic       addr_valid = 1'b0, data_req = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic [7:0] addr_byte = 8'h00;
  logic [7:0] reg_addr, reg_rdata, data;
  logic       data_valid, adc_start;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem(input int a);
    return 8'(a * 37 + 11);
  endfunction

  assign reg_rdata = mem(int'(reg_addr));

  reg_read_sequencer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .short_mode_i(short_mode), .trig_sel_i(trig_sel),
    .start_i(start), .stop_i(stop), .addr_valid_i(addr_valid), .addr_byte_i(addr_byte),
    .data_req_i(data_req), .reg_addr_o(reg_addr), .reg_rdata_i(reg_rdata),
    .data_o(data), .data_valid_o(data_valid), .adc_start_o(adc_start)
  );

  int errors = 0, checks = 0;
  int adc_seen = 0;
  string scen = "R1";
  bit finished = 0;

  // Behavioural reference model
  bit m_active = 0, m_short = 0, m_fired = 0;
  int m_trig = 0, m_ptr = 0;
  bit e_valid = 0, e_adc = 0;
  int e_data = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_short = 0; m_fired = 0; m_trig = 0; m_ptr = 0;
      e_valid = 0; e_adc = 0; e_data = 0;
    end else begin
      e_valid = 0; e_adc = 0;
      if (start) begin
        m_active = 1; m_short = short_mode; m_trig = int'(trig_sel); m_fired = 0;
        if (short_mode) m_ptr = 0;
        if (short_mode && trig_sel == 2'b01) begin e_adc = 1; m_fired = 1; end
      end else if (stop) begin
        m_active = 0;
      end else if (m_active) begin
        if (addr_valid && !m_short) m_ptr = int'(addr_byte);
        else if (data_req) begin
          e_valid = 1;
          e_data = (m_ptr < NREG) ? int'(mem(m_ptr)) : 0;
          if (m_short && m_trig >= 2 && m_ptr == 5 && !m_fired) begin e_adc = 1; m_fired = 1; end
          m_ptr = (m_ptr >= NREG - 1) ? 0 : m_ptr + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (scenario %s): actual=%0h expected=%0h at %0t", req, scen, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string atag;
      if (adc_start) adc_seen++;
      if (!m_short) atag = "R7";
      else if (m_trig == 0) atag = "R8";
      else if (m_trig == 1) atag = "R9";
      else atag = "R10";
      check(data_valid == e_valid, "R3", int'(data_valid), int'(e_valid));
      check(adc_start == e_adc, atag, int'(adc_start), int'(e_adc));
      check(int'(reg_addr) == m_ptr, "R5", int'(reg_addr), m_ptr);
      if (e_valid) check(int'(data) == e_data, (e_data == 0) ? "R6" : "R3", int'(data), e_data);
    end
  end

  task automatic do_start(input bit s, input logic [1:0] t);
    @(negedge clk); start = 1; short_mode = s; trig_sel = t; adc_seen = 0;
    @(negedge clk); start = 0;
  endtask
  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask
  task automatic do_addr(input logic [7:0] a);
    @(negedge clk); addr_valid = 1; addr_byte = a;
    @(negedge clk); addr_valid = 0;
  endtask
  task automatic do_reads(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); data_req = 1;
    end
    @(negedge clk); data_req = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(data_valid == 0 && adc_start == 0, "R1", int'({data_valid, adc_start}), 0);
    check(reg_addr == 8'h00 && data == 8'h00, "R1", int'({reg_addr, data}), 0);
    rst_n = 1;
    @(negedge clk);

    scen = "R3"; do_reads(3);                 // no transaction yet: ignored
    check(reg_addr == 8'h00, "R3", int'(reg_addr), 0);

    scen = "R4"; do_start(0, 2'b11); do_addr(8'h03); do_reads(6); do_stop();
    check(adc_seen == 0, "R7", adc_seen, 0);
    check(reg_addr == 8'h09, "R4", int'(reg_addr), 9);

    scen = "R5"; do_start(0, 2'b10); do_addr(8'h14); do_reads(5); do_stop();
    check(reg_addr == 8'h02, "R5", int'(reg_addr), 2);

    scen = "R6"; do_start(0, 2'b00); do_addr(8'h30); do_reads(3); do_stop();

    scen = "R2"; do_start(1, 2'b00); do_addr(8'h09); do_reads(8); do_stop();
    check(adc_seen == 0, "R8", adc_seen, 0);
    check(reg_addr == 8'h08, "R2", int'(reg_addr), 8);

    scen = "R9"; do_start(1, 2'b01); do_reads(3); do_stop();
    check(adc_seen == 1, "R9", adc_seen, 1);

    scen = "R10"; do_start(1, 2'b10); do_reads(30); do_stop();
    check(adc_seen == 1, "R10", adc_seen, 1);
    do_start(1, 2'b11); do_reads(7); do_stop();
    check(adc_seen == 1, "R10", adc_seen, 1);

    scen = "R11"; do_start(1, 2'b10);
    short_mode = 0; trig_sel = 2'b01;
    do_addr(8'h04); do_reads(8); do_stop();
    check(adc_seen == 1, "R11", adc_seen, 1);
    check(reg_addr == 8'h08, "R11", int'(reg_addr), 8);

    scen = "R3"; do_reads(4);                 // after stop: ignored
    check(reg_addr == 8'h08, "R3", int'(reg_addr), 8);

    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule